// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block gives a host controller access to a small bank of configuration registers over a three-wire serial link. The link has an active-low select, a serial clock that idles low, and one shared data line. At the pads the data line is split into an input, an output and an output enable. Every transaction has 17 bits and begins while select is low. The first bit is the direction, the next eight are the register address, and the last eight are the data byte, each field most significant bit first. On a write the host drives every bit. On a read the host drives the direction and address bits, and the slave then takes over the line and returns the addressed byte.

The serial inputs are brought into the system clock domain through synchronizers, so the whole block runs on the system clock. The serial clock must therefore run well below the system clock. The register bank holds ordinary read/write registers and one write-only register whose value is read back at a separate mirror address. It also holds a read-only identification byte and a reset bit that clears itself after a set number of system clock cycles. Every register drives a parallel output.

Top module: `spi3_reg_slave`

## Requirements
- R1: After reset: `ctrl_q` = 00h, `pwr_q` = 00h, `cfg_q` = 3Ch, every byte of `gp_q` = 00h and `sdio_oe` = 0.
- R2: A write frame has the direction bit 0, then address bits 7..0, then data bits 7..0. The block samples each bit on a rising serial clock edge. The target register takes the data byte only after the 17th bit.
- R3: In a read frame (direction bit 1), the slave drives data bit 7 on the falling edge after the last address bit. It drives each following bit, down to bit 0, on the next falling edge. The host samples each bit on the rising edge that follows.
- R4: `sdio_oe` is high only during the data phase of a read frame. It is low during write frames and during the direction and address bits. It goes low in the same instant that `sel_n` goes high.
- R5: If select rises before the 17th bit, no register changes. This applies to writes cut off in either the address phase or the data phase.
- R6: Address 08h is write-only and drives `cfg_q`; a read of 08h returns 00h. A read of address 09h returns the contents of 08h. A write to 09h has no effect.
- R7: Address 1Eh returns the identification byte 5Ah. A write to it has no effect.
- R8: Address 00h drives `ctrl_q`. Writing bit 0 as 1 raises `ctrl_q[0]` for exactly `SCLR_CYCLES` system clock cycles, after which it clears. Bits 7..1 keep the written value.
- R9: An address with no register reads 00h. A write to it changes no output.
- R10: Address 01h (`pwr_q`) and the `NUM_GP` general registers at 02h upward (byte k of `gp_q` at address 02h+k) can be read and written.
- R11: Any serial clock edges after the 17th bit of a frame are ignored. The committed value is the one from the first 17 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock, idles low |
| sdio_in | input | 1 | Data line as received from the pad |
| sdio_out | output | 1 | Read data driven toward the pad |
| sdio_oe | output | 1 | Pad output enable for read data |
| ctrl_q | output | 8 | Control register; bit 0 is the self-clearing reset |
| pwr_q | output | 8 | Power control register |
| cfg_q | output | 8 | Write-only configuration register |
| gp_q | output | 8*NUM_GP | General registers, byte k at address 02h+k |

## Verification
The hardest cases to reach are frames that end early. In these the select line rises after some address or data bits but before the last one, and the register bank must stay exactly as it was. The driver task takes a bit count, so it can cut off a write after 12 or 16 bits, or cut off a read partway through its data phase. It can also run past 17 bits. After each such frame the bench checks the register outputs and checks that the output enable drops at the instant select rises. Read data goes through a scoreboard. The driver queues the expected byte, and a monitor collects the bits the slave drives on the host's rising edges and compares them with the queued byte.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
   localparam int ADDR_W     = 8;
   localparam int DATA_W     = 8;
   localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);

   typedef logic [DATA_W-1:0] byte_t;
   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [CNT_W-1:0]  cnt_t;

   // bit counter landmarks (count of bits already received)
   localparam cnt_t CNT_ADDR_LAST  = cnt_t'(ADDR_W);
   localparam cnt_t CNT_DATA_FIRST = cnt_t'(ADDR_W + 1);
   localparam cnt_t CNT_DATA_LAST  = cnt_t'(FRAME_BITS - 1);
   localparam cnt_t CNT_FRAME      = cnt_t'(FRAME_BITS);
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
   parameter int         W       = 1,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi3_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("spi3_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage[g] <= RST_VAL;
            end else if (g == 0) begin
               stage[g] <= d;
            end else begin
               stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
   import spi3_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sel_s,
   input  logic  sclk_s,
   input  logic  sdi_s,
   input  byte_t rd_data,
   output addr_t rd_addr,
   output logic  wr_stb,
   output addr_t wr_addr,
   output byte_t wr_data,
   output logic  sdo,
   output logic  oe
);
   logic  sclk_d;
   logic  sclk_rise, sclk_fall;
   cnt_t  bit_cnt;
   logic  rw_q;
   byte_t shreg;
   addr_t addr_q;
   logic  rd_pend;
   byte_t rd_sh;
   logic  sdo_q, oe_q;
   logic  wr_stb_q;
   byte_t wr_data_q;
   cnt_t  rd_idx;
   byte_t shreg_next;

   assign sclk_rise  = sclk_s & ~sclk_d;
   assign sclk_fall  = ~sclk_s & sclk_d;
   assign rd_idx     = CNT_DATA_LAST - bit_cnt;
   assign shreg_next = {shreg[DATA_W-2:0], sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d    <= 1'b0;
         bit_cnt   <= '0;
         rw_q      <= 1'b0;
         shreg     <= '0;
         addr_q    <= '0;
         rd_pend   <= 1'b0;
         rd_sh     <= '0;
         sdo_q     <= 1'b0;
         oe_q      <= 1'b0;
         wr_stb_q  <= 1'b0;
         wr_data_q <= '0;
      end else begin
         sclk_d   <= sclk_s;
         wr_stb_q <= 1'b0;
         rd_pend  <= 1'b0;
         if (rd_pend) begin
            rd_sh <= rd_data;
         end
         if (sel_s) begin
            bit_cnt <= '0;
            oe_q    <= 1'b0;
         end else begin
            if (sclk_rise && (bit_cnt < CNT_FRAME)) begin
               shreg   <= shreg_next;
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == '0) begin
                  rw_q <= sdi_s;
               end
               if (bit_cnt == CNT_ADDR_LAST) begin
                  addr_q  <= shreg_next;
                  rd_pend <= rw_q;
               end
               if ((bit_cnt == CNT_DATA_LAST) && !rw_q) begin
                  wr_stb_q  <= 1'b1;
                  wr_data_q <= shreg_next;
               end
            end
            if (sclk_fall && rw_q && (bit_cnt >= CNT_DATA_FIRST) && (bit_cnt < CNT_FRAME)) begin
               oe_q  <= 1'b1;
               sdo_q <= rd_sh[rd_idx[2:0]];
            end
         end
      end
   end

   assign rd_addr = addr_q;
   assign wr_addr = addr_q;
   assign wr_stb  = wr_stb_q;
   assign wr_data = wr_data_q;
   assign sdo     = sdo_q;
   assign oe      = oe_q;

   // R4: the driver is only enabled in a read frame
   a_r4_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> rw_q);
   // R4: the driver is never enabled before the data phase
   a_r4_oe_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (bit_cnt >= CNT_DATA_FIRST));
   // R2: a commit only follows a complete frame
   a_r2_commit_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_q |-> (bit_cnt == CNT_FRAME));
   // R3: the read bit changes only on a falling serial edge
   a_r3_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(sdo_q));
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile
   import spi3_pkg::*;
#(
   parameter int    NUM_GP       = 4,
   parameter int    SCLR_CYCLES  = 400,
   parameter addr_t ADDR_CTRL    = 8'h00,
   parameter addr_t ADDR_PWR     = 8'h01,
   parameter addr_t ADDR_GP_BASE = 8'h02,
   parameter addr_t ADDR_WO      = 8'h08,
   parameter addr_t ADDR_MIRROR  = 8'h09,
   parameter addr_t ADDR_ID      = 8'h1E,
   parameter byte_t CHIP_ID      = 8'h5A,
   parameter byte_t CTRL_RST     = 8'h00,
   parameter byte_t PWR_RST      = 8'h00,
   parameter byte_t WO_RST       = 8'h3C,
   parameter byte_t GP_RST       = 8'h00
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  addr_t                    wr_addr,
   input  byte_t                    wr_data,
   input  addr_t                    rd_addr,
   output byte_t                    rd_data,
   output byte_t                    ctrl_q,
   output byte_t                    pwr_q,
   output byte_t                    cfg_q,
   output logic [NUM_GP*DATA_W-1:0] gp_q
);
   localparam int    SCLR_W    = $clog2(SCLR_CYCLES + 1);
   localparam int    GP_LAST   = int'(ADDR_GP_BASE) + NUM_GP - 1;
   localparam logic [SCLR_W-1:0] SCLR_LOAD = SCLR_W'(SCLR_CYCLES - 1);

   generate
      if (SCLR_CYCLES < 1) begin : g_bad_sclr
         $error("spi3_regfile: SCLR_CYCLES must be at least 1");
      end
      if (NUM_GP < 1 || GP_LAST > 255) begin : g_bad_gp
         $error("spi3_regfile: general register range does not fit the address space");
      end
      if (ADDR_WO == ADDR_MIRROR || ADDR_ID == ADDR_MIRROR || ADDR_ID == ADDR_WO ||
          ADDR_CTRL == ADDR_PWR || ADDR_CTRL == ADDR_WO || ADDR_CTRL == ADDR_MIRROR ||
          ADDR_CTRL == ADDR_ID || ADDR_PWR == ADDR_WO || ADDR_PWR == ADDR_MIRROR ||
          ADDR_PWR == ADDR_ID) begin : g_bad_map
         $error("spi3_regfile: register addresses collide");
      end
   endgenerate

   logic [SCLR_W-1:0] sclr_cnt;
   byte_t             ctrl_r, pwr_r, wo_r;

   // control, power and write-only registers with the self-clearing reset bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_r   <= {CTRL_RST[DATA_W-1:1], 1'b0};
         sclr_cnt <= '0;
         pwr_r    <= PWR_RST;
         wo_r     <= WO_RST;
      end else begin
         if (ctrl_r[0]) begin
            if (sclr_cnt == '0) begin
               ctrl_r[0] <= 1'b0;
            end else begin
               sclr_cnt <= sclr_cnt - 1'b1;
            end
         end
         if (wr_stb) begin
            if (wr_addr == ADDR_CTRL) begin
               ctrl_r   <= wr_data;
               sclr_cnt <= wr_data[0] ? SCLR_LOAD : '0;
            end
            if (wr_addr == ADDR_PWR) begin
               pwr_r <= wr_data;
            end
            if (wr_addr == ADDR_WO) begin
               wo_r <= wr_data;
            end
         end
      end
   end

   byte_t gp_r  [NUM_GP];
   byte_t gp_rd [NUM_GP];

   genvar g;
   generate
      for (g = 0; g < NUM_GP; g++) begin : g_gp
         localparam addr_t GP_ADDR = addr_t'(int'(ADDR_GP_BASE) + g);
         if (GP_ADDR == ADDR_CTRL || GP_ADDR == ADDR_PWR || GP_ADDR == ADDR_WO ||
             GP_ADDR == ADDR_MIRROR || GP_ADDR == ADDR_ID) begin : g_clash
            $error("spi3_regfile: general register overlaps a fixed register");
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gp_r[g] <= GP_RST;
            end else if (wr_stb && (wr_addr == GP_ADDR)) begin
               gp_r[g] <= wr_data;
            end
         end
         assign gp_rd[g] = (rd_addr == GP_ADDR) ? gp_r[g] : '0;
         assign gp_q[g*DATA_W +: DATA_W] = gp_r[g];
      end
   endgenerate

   // read multiplexer: the write-only address and unmapped space return zero
   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_CTRL) begin
         rd_data = ctrl_r;
      end else if (rd_addr == ADDR_PWR) begin
         rd_data = pwr_r;
      end else if (rd_addr == ADDR_MIRROR) begin
         rd_data = wo_r;
      end else if (rd_addr == ADDR_ID) begin
         rd_data = CHIP_ID;
      end
      for (int k = 0; k < NUM_GP; k++) begin
         rd_data = rd_data | gp_rd[k];
      end
   end

   assign ctrl_q = ctrl_r;
   assign pwr_q  = pwr_r;
   assign cfg_q  = wo_r;

   // R8: the countdown is idle whenever the reset bit is clear
   a_r8_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_r[0] |-> (sclr_cnt == '0));
   // R5: without a commit strobe the stored registers hold
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(pwr_r) && $stable(wo_r) && $stable(gp_q) && $stable(ctrl_r[DATA_W-1:1])));
endmodule

// File: rtl/spi3_reg_slave.sv
module spi3_reg_slave
   import spi3_pkg::*;
#(
   parameter int    NUM_GP      = 4,
   parameter int    SCLR_CYCLES = 400,
   parameter int    SYNC_STAGES = 2,
   parameter byte_t CHIP_ID     = 8'h5A
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sel_n,
   input  logic                     sclk,
   input  logic                     sdio_in,
   output logic                     sdio_out,
   output logic                     sdio_oe,
   output logic [DATA_W-1:0]        ctrl_q,
   output logic [DATA_W-1:0]        pwr_q,
   output logic [DATA_W-1:0]        cfg_q,
   output logic [NUM_GP*DATA_W-1:0] gp_q
);
   logic [2:0] raw_in, sync_out;
   logic       sel_s, sclk_s, sdi_s;
   addr_t      rd_addr, wr_addr;
   byte_t      rd_data, wr_data;
   logic       wr_stb;
   logic       oe_int;

   assign raw_in = {sel_n, sclk, sdio_in};

   spi3_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   assign sel_s  = sync_out[2];
   assign sclk_s = sync_out[1];
   assign sdi_s  = sync_out[0];

   spi3_frame u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_s   (sel_s),
      .sclk_s  (sclk_s),
      .sdi_s   (sdi_s),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sdo     (sdio_out),
      .oe      (oe_int)
   );

   spi3_regfile #(
      .NUM_GP      (NUM_GP),
      .SCLR_CYCLES (SCLR_CYCLES),
      .CHIP_ID     (CHIP_ID)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .ctrl_q  (ctrl_q),
      .pwr_q   (pwr_q),
      .cfg_q   (cfg_q),
      .gp_q    (gp_q)
   );

   // release the pad the moment select rises, ahead of the synchronizer
   assign sdio_oe = oe_int & ~sel_n;
endmodule

// File: tb/spi3_reg_slave_tb.sv
module spi3_reg_slave_tb;
   localparam int NUM_GP = 4;
   localparam int SCLR   = 40;
   localparam int HALF   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1;
   logic sclk = 1'b0;
   logic sdio_in = 1'b0;
   logic sdio_out, sdio_oe;
   logic [7:0] ctrl_q, pwr_q, cfg_q;
   logic [NUM_GP*8-1:0] gp_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   spi3_reg_slave #(.NUM_GP(NUM_GP), .SCLR_CYCLES(SCLR)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdio_in(sdio_in),
      .sdio_out(sdio_out), .sdio_oe(sdio_oe), .ctrl_q(ctrl_q), .pwr_q(pwr_q),
      .cfg_q(cfg_q), .gp_q(gp_q));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic spi_frame(input logic rw, input logic [7:0] a, input logic [7:0] d, input int nbits);
      logic [16:0] fr;
      fr = {rw, a, d};
      sel_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         if (i < 17 && !(rw && i >= 9)) sdio_in = fr[16-i];
         else sdio_in = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      sel_n = 1'b1;
      #1;
      chk(sdio_oe, 0, "R4 output enable drops with select");
      repeat (10) @(negedge clk);
   endtask

   task automatic spi_write(input logic [7:0] a, input logic [7:0] d);
      spi_frame(1'b0, a, d, 17);
   endtask

   task automatic spi_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      spi_frame(1'b1, a, 8'h00, 17);
   endtask

   // monitor: follows each frame on the host's rising edges
   initial begin : monitor
      int cnt;
      logic rwb;
      logic [7:0] got;
      string tg;
      cnt = 0; rwb = 1'b0; got = '0;
      forever begin
         @(posedge sclk or negedge sel_n);
         if (!sclk) begin
            cnt = 0;
         end else begin
            cnt++;
            if (cnt == 1) rwb = sdio_in;
            if (rwb && cnt >= 10 && cnt <= 17) begin
               got = {got[6:0], sdio_out};
               chk(sdio_oe, 1, "R4 enable during read data");
               if (cnt == 17) begin
                  if (exp_q.size() == 0) begin
                     chk(got, 32'hDEAD, "R3 unexpected read result");
                  end else begin
                     tg = tag_q.pop_front();
                     chk(got, exp_q.pop_front(), tg);
                  end
               end
            end else if (cnt <= 17) begin
               chk(sdio_oe, 0, "R4 enable outside read data");
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      int n;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk(ctrl_q, 8'h00, "R1 ctrl reset");
      chk(pwr_q, 8'h00, "R1 pwr reset");
      chk(cfg_q, 8'h3C, "R1 cfg reset");
      chk(gp_q, '0, "R1 gp reset");
      chk(sdio_oe, 0, "R1 enable reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R7 identification, R3 read path
      spi_read(8'h1E, 8'h5A, "R7 R3 id read");

      // R2 R10 writes and readback
      spi_write(8'h02, 8'hA5);
      chk(gp_q[7:0], 8'hA5, "R2 R10 gp0 write");
      spi_write(8'h05, 8'h3C);
      chk(gp_q[31:24], 8'h3C, "R10 gp3 write");
      spi_write(8'h01, 8'h81);
      chk(pwr_q, 8'h81, "R10 pwr write");
      spi_read(8'h02, 8'hA5, "R3 R10 gp0 read");
      spi_read(8'h05, 8'h3C, "R3 R10 gp3 read");
      spi_read(8'h01, 8'h81, "R3 R10 pwr read");

      // R6 write-only register and mirror
      spi_write(8'h08, 8'h96);
      chk(cfg_q, 8'h96, "R6 cfg write");
      spi_read(8'h08, 8'h00, "R6 write-only reads zero");
      spi_read(8'h09, 8'h96, "R6 mirror read");
      spi_write(8'h09, 8'h11);
      chk(cfg_q, 8'h96, "R6 mirror write ignored");
      spi_read(8'h09, 8'h96, "R6 mirror unchanged");

      // R7 identification ignores writes
      spi_write(8'h1E, 8'h00);
      spi_read(8'h1E, 8'h5A, "R7 id after write");

      // R9 unmapped address
      spi_write(8'h40, 8'hFF);
      chk({ctrl_q, pwr_q, cfg_q}, {8'h00, 8'h81, 8'h96}, "R9 write ignored");
      chk(gp_q, {8'h3C, 8'h00, 8'h00, 8'hA5}, "R9 gp untouched");
      spi_read(8'h40, 8'h00, "R9 unmapped reads zero");

      // R5 aborted frames
      spi_frame(1'b0, 8'h03, 8'h77, 12);
      chk(gp_q[15:8], 8'h00, "R5 abort in data phase (12 bits)");
      spi_frame(1'b0, 8'h03, 8'h77, 16);
      chk(gp_q[15:8], 8'h00, "R5 abort before last bit");
      spi_frame(1'b0, 8'h08, 8'h00, 5);
      chk(cfg_q, 8'h96, "R5 abort in address phase");
      spi_frame(1'b1, 8'h02, 8'h00, 12);
      chk(gp_q[7:0], 8'hA5, "R5 aborted read leaves gp0");

      // R11 extra clocks ignored
      spi_frame(1'b0, 8'h04, 8'h5C, 20);
      chk(gp_q[23:16], 8'h5C, "R11 extra bits ignored");
      spi_read(8'h04, 8'h5C, "R11 readback");

      // R8 self-clearing reset bit
      n = 0;
      fork
         spi_write(8'h00, 8'hA1);
         begin
            @(posedge ctrl_q[0]);
            chk(ctrl_q[7:1], 7'h50, "R8 upper bits while active");
            do begin
               @(negedge clk);
               if (ctrl_q[0]) n++;
            end while (ctrl_q[0]);
         end
      join
      chk(n, SCLR, "R8 self-clear duration");
      chk(ctrl_q, 8'hA0, "R8 after self-clear");
      spi_read(8'h00, 8'hA0, "R8 readback after clear");

      repeat (20) @(negedge clk);
      chk(exp_q.size(), 0, "R3 all reads observed");
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule